// File: doc/BRIEF.md
# Dual-Clock FIFO with Write-Synchronous Reset Handshake

This block is a first-in first-out buffer whose write and read ports run on unrelated clocks. Most of its logic exists to put the buffer into a known state and bring it out again cleanly. A single reset request, sampled on the write clock and possibly only one cycle long, clears the write pointer, counters and registered status. The write side holds a reset request, synchronizes it into the read clock domain, and waits for the read side to confirm that it has entered reset and then left it.

While this handshake runs, the write side raises a busy output and both ports ignore their enables. The busy output falls only after the read domain has left reset. That fall is the point from which the buffer may be used. Status outputs have defined values at power-up and while reset is in effect. The full-type flags take a build-time value during reset, so that setting it to 1 shuts out writers.

Write and read pointers cross between the domains as Gray codes. Occupancy counts are derived on each side from the local pointer and the synchronized remote pointer. Programmable full and empty thresholds are static parameters.

Top module: `dcfifo_rstctl`

## Requirements
- R1: A reset pulse of one write-clock cycle is enough. `wr_rst_busy` is 1 at the first write-clock edge after the pulse. It stays 1 for at least three write cycles while the read domain enters and then leaves reset, and then returns to 0 by itself.
- R2: While `wr_rst_busy` is 1, `wr_full`, `wr_almost_full` and `wr_prog_full` all equal the parameter FULL_RST_VAL, and `wr_count`, `wr_ack` and `wr_overflow` are 0.
- R3: While the read domain is in reset, `rd_empty`, `rd_almost_empty` and `rd_prog_empty` are 1, and `rd_count` and `rd_valid` are 0. `rd_data` equals the parameter DOUT_RST_VAL, and it keeps that value after the read domain leaves reset until a read succeeds.
- R4: At power-up, before any reset, the full-type flags, both counts, `wr_ack`, `wr_overflow`, `rd_valid`, `rd_underflow` and `wr_rst_busy` are 0. The empty-type flags are 1 and `rd_data` equals DOUT_RST_VAL.
- R5: Write enables presented during the reset cycle or the busy window are ignored. No acknowledge is given and no word is stored, so `wr_count` is 0 and `rd_empty` is 1 afterwards.
- R6: Words are read out in the order they were written. An accepted write raises `wr_ack` for the cycle after the write clock edge that takes it. A successful read updates `rd_data` and raises `rd_valid` one read-clock edge later.
- R7: A write while `wr_full` is 1 raises `wr_overflow` on the next write cycle. It gives no acknowledge and leaves the buffer contents and `wr_count` unchanged.
- R8: A read while `rd_empty` is 1 raises `rd_underflow` on the next read cycle. It leaves `rd_valid` at 0 and `rd_data` unchanged.
- R9: `wr_full` is 1 exactly when `wr_count` equals DEPTH, and `wr_almost_full` is 1 when `wr_count` is at least DEPTH-1. `rd_empty` is 1 when `rd_count` is 0, and `rd_almost_empty` is 1 when `rd_count` is at most 1.
- R10: `wr_prog_full` is 1 when `wr_count` is at least PROG_FULL_LVL. `rd_prog_empty` is 1 when `rd_count` is at most PROG_EMPTY_LVL.
- R11: A reset applied while words are stored discards them. Once busy has fallen, both counts are 0, `rd_empty` is 1 and `wr_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Reset request, active high, synchronous to wr_clk |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| wr_full | output | 1 | Buffer holds DEPTH words |
| wr_almost_full | output | 1 | At most one free slot |
| wr_prog_full | output | 1 | Occupancy at or above PROG_FULL_LVL |
| wr_ack | output | 1 | Previous write was accepted |
| wr_overflow | output | 1 | Previous write was refused (full) |
| wr_count | output | AW+1 | Write-side occupancy |
| wr_rst_busy | output | 1 | Reset handshake in progress |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered read word |
| rd_valid | output | 1 | rd_data was updated by the previous read |
| rd_empty | output | 1 | No word available |
| rd_almost_empty | output | 1 | At most one word available |
| rd_prog_empty | output | 1 | Occupancy at or below PROG_EMPTY_LVL |
| rd_underflow | output | 1 | Previous read was refused (empty) |
| rd_count | output | AW+1 | Read-side occupancy |

## Verification
A handshake state that is stuck or skips a step shows up at once as a busy output that never falls or falls too early. The bench times that fall against a bound of a few write cycles. A pointer that is not cleared, or a Gray crossing that is out of step, gives a wrong `wr_count` or `rd_count`. It also gives a word out of order within a few cycles of the next transfer, which the bench catches when it fills the buffer, drains it and then resets it with data still inside. A flag chosen from the wrong source during reset shows as a full or empty value that differs from the parameter on the first write cycle after the pulse.

// File: rtl/dcfifo_rst_pkg.sv
package dcfifo_rst_pkg;

    localparam int GW = 16;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_REQ  = 2'd1,
        RS_REL  = 2'd2
    } rst_state_e;

    typedef struct packed {
        logic full;
        logic almost;
        logic prog;
    } side_flags_t;

    function automatic logic [GW-1:0] bin2gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW-1:0] gray2bin(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         srst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES] = '{default: '0};

    always_ff @(posedge clk) begin
        if (srst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcfifo_rst_pkg::*;
#(
    parameter int   DEPTH         = 8,
    parameter int   PROG_FULL_LVL = 6,
    parameter logic FULL_RST_VAL  = 1'b1,
    localparam int  AW            = $clog2(DEPTH),
    localparam int  PW            = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_in_rst,
    input  logic [PW-1:0] rgray_sync,
    output logic          req,
    output logic          busy,
    output logic          hold,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output side_flags_t   flags,
    output logic          ack,
    output logic          ovf,
    output logic [PW-1:0] count
);
    rst_state_e    st    = RS_IDLE;
    logic          req_q = 1'b0;
    logic [PW-1:0] wbin  = '0;
    logic [PW-1:0] wg_q  = '0;
    logic          ack_q = 1'b0;
    logic          ovf_q = 1'b0;
    logic [PW-1:0] rbin, occ, wbin_n;
    logic          at_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RS_REQ;
            req_q <= 1'b1;
        end else begin
            case (st)
                RS_REQ: if (rd_in_rst) begin
                    st    <= RS_REL;
                    req_q <= 1'b0;
                end
                RS_REL: if (!rd_in_rst) st <= RS_IDLE;
                default: ;
            endcase
        end
    end

    assign busy    = (st != RS_IDLE);
    assign hold    = rst | busy;
    assign req     = req_q;
    assign rbin    = PW'(gray2bin(GW'(rgray_sync)));
    assign occ     = wbin - rbin;
    assign at_full = (occ == PW'(DEPTH));
    assign we      = wr_en & ~hold & ~at_full;
    assign wbin_n  = wbin + PW'(1);

    always_ff @(posedge clk) begin
        if (hold) begin
            wbin  <= '0;
            wg_q  <= '0;
            ack_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            ack_q <= we;
            ovf_q <= wr_en & at_full;
            if (we) begin
                wbin <= wbin_n;
                wg_q <= PW'(bin2gray(GW'(wbin_n)));
            end
        end
    end

    assign waddr        = wbin[AW-1:0];
    assign wgray        = wg_q;
    assign ack          = ack_q;
    assign ovf          = ovf_q;
    assign count        = busy ? '0 : occ;
    assign flags.full   = busy ? FULL_RST_VAL : at_full;
    assign flags.almost = busy ? FULL_RST_VAL : (occ >= PW'(DEPTH - 1));
    assign flags.prog   = busy ? FULL_RST_VAL : (occ >= PW'(PROG_FULL_LVL));

    a_r1_busy_after_pulse: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> busy);
    a_r1_busy_falls_after_release: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!rd_in_rst && !req_q));
    a_r7_overflow_keeps_state: assert property (@(posedge clk) disable iff (rst)
        (wr_en && at_full && !hold) |=> ($stable(wbin) && !ack_q && ovf_q));
    a_r6_ack_excludes_overflow: assert property (@(posedge clk) disable iff (rst)
        !(ack_q && ovf_q));
    a_r9_wr_count_bound: assert property (@(posedge clk) disable iff (rst)
        occ <= PW'(DEPTH));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcfifo_rst_pkg::*;
#(
    parameter int          DEPTH          = 8,
    parameter int          WIDTH          = 8,
    parameter int          PROG_EMPTY_LVL = 2,
    parameter logic [WIDTH-1:0] DOUT_RST_VAL = '0,
    localparam int         AW             = $clog2(DEPTH),
    localparam int         PW             = AW + 1
) (
    input  logic             clk,
    input  logic             rd_rst,
    input  logic             rd_en,
    input  logic [PW-1:0]    wgray_sync,
    input  logic [WIDTH-1:0] mem_q,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rgray,
    output logic [WIDTH-1:0] dout,
    output logic             valid,
    output logic             unf,
    output side_flags_t      flags,
    output logic [PW-1:0]    count
);
    logic [PW-1:0]    rbin    = '0;
    logic [PW-1:0]    rg_q    = '0;
    logic [WIDTH-1:0] dout_q  = DOUT_RST_VAL;
    logic             valid_q = 1'b0;
    logic             unf_q   = 1'b0;
    logic [PW-1:0]    wbin, occ, rbin_n;
    logic             none, take;

    assign wbin   = PW'(gray2bin(GW'(wgray_sync)));
    assign occ    = wbin - rbin;
    assign none   = (occ == '0);
    assign take   = rd_en & ~rd_rst & ~none;
    assign rbin_n = rbin + PW'(1);

    always_ff @(posedge clk) begin
        if (rd_rst) begin
            rbin    <= '0;
            rg_q    <= '0;
            dout_q  <= DOUT_RST_VAL;
            valid_q <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            valid_q <= take;
            unf_q   <= rd_en & none;
            if (take) begin
                dout_q <= mem_q;
                rbin   <= rbin_n;
                rg_q   <= PW'(bin2gray(GW'(rbin_n)));
            end
        end
    end

    assign raddr        = rbin[AW-1:0];
    assign rgray        = rg_q;
    assign dout         = dout_q;
    assign valid        = valid_q;
    assign unf          = unf_q;
    assign count        = rd_rst ? '0 : occ;
    assign flags.full   = rd_rst | none;
    assign flags.almost = rd_rst | (occ <= PW'(1));
    assign flags.prog   = rd_rst | (occ <= PW'(PROG_EMPTY_LVL));

    a_r8_underflow_keeps_state: assert property (@(posedge clk) disable iff (rd_rst)
        (rd_en && none) |=> ($stable(rbin) && $stable(dout_q) && !valid_q && unf_q));
    a_r6_valid_needs_request: assert property (@(posedge clk) disable iff (rd_rst)
        valid_q |-> $past(rd_en));
    a_r9_rd_count_bound: assert property (@(posedge clk) disable iff (rd_rst)
        occ <= PW'(DEPTH));
endmodule

// File: rtl/dcfifo_rstctl.sv
module dcfifo_rstctl
    import dcfifo_rst_pkg::*;
#(
    parameter int               WIDTH          = 8,
    parameter int               DEPTH          = 8,
    parameter int               SYNC_STAGES    = 2,
    parameter int               PROG_FULL_LVL  = 6,
    parameter int               PROG_EMPTY_LVL = 2,
    parameter logic             FULL_RST_VAL   = 1'b1,
    parameter logic [WIDTH-1:0] DOUT_RST_VAL   = '0,
    localparam int              AW             = $clog2(DEPTH),
    localparam int              PW             = AW + 1
) (
    input  logic             rst,
    input  logic             wr_clk,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_full,
    output logic             wr_almost_full,
    output logic             wr_prog_full,
    output logic             wr_ack,
    output logic             wr_overflow,
    output logic [PW-1:0]    wr_count,
    output logic             wr_rst_busy,
    input  logic             rd_clk,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             rd_empty,
    output logic             rd_almost_empty,
    output logic             rd_prog_empty,
    output logic             rd_underflow,
    output logic [PW-1:0]    rd_count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic             req, busy, hold, we, rd_rst, rd_in_rst;
    logic [AW-1:0]    waddr, raddr;
    logic [PW-1:0]    wgray, rgray, wgray_rs, rgray_ws;
    side_flags_t      wfl, rfl;

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wr_data;
    end

    dcf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(rd_clk), .srst(1'b0), .d(req), .q(rd_rst));
    dcf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(wr_clk), .srst(1'b0), .d(rd_rst), .q(rd_in_rst));
    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
        .clk(rd_clk), .srst(rd_rst), .d(wgray), .q(wgray_rs));
    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
        .clk(wr_clk), .srst(hold), .d(rgray), .q(rgray_ws));

    dcf_wr_ctrl #(
        .DEPTH(DEPTH), .PROG_FULL_LVL(PROG_FULL_LVL), .FULL_RST_VAL(FULL_RST_VAL)
    ) u_wr (
        .clk(wr_clk), .rst(rst), .wr_en(wr_en), .rd_in_rst(rd_in_rst),
        .rgray_sync(rgray_ws), .req(req), .busy(busy), .hold(hold), .we(we),
        .waddr(waddr), .wgray(wgray), .flags(wfl), .ack(wr_ack),
        .ovf(wr_overflow), .count(wr_count));

    dcf_rd_ctrl #(
        .DEPTH(DEPTH), .WIDTH(WIDTH), .PROG_EMPTY_LVL(PROG_EMPTY_LVL),
        .DOUT_RST_VAL(DOUT_RST_VAL)
    ) u_rd (
        .clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .wgray_sync(wgray_rs),
        .mem_q(mem[raddr]), .raddr(raddr), .rgray(rgray), .dout(rd_data),
        .valid(rd_valid), .unf(rd_underflow), .flags(rfl), .count(rd_count));

    assign wr_rst_busy     = busy;
    assign wr_full         = wfl.full;
    assign wr_almost_full  = wfl.almost;
    assign wr_prog_full    = wfl.prog;
    assign rd_empty        = rfl.full;
    assign rd_almost_empty = rfl.almost;
    assign rd_prog_empty   = rfl.prog;

    a_r2_full_value_while_busy: assert property (@(posedge wr_clk) disable iff (rst)
        wr_rst_busy |-> (wr_full == FULL_RST_VAL && wr_count == '0));
    a_r5_no_store_while_busy: assert property (@(posedge wr_clk) disable iff (rst)
        $past(wr_rst_busy) |-> !wr_ack);
endmodule

// File: tb/dcfifo_rstctl_test.sv
`timescale 1ns/1ps
module dcfifo_rstctl_test;
    localparam int         W    = 8;
    localparam int         D    = 8;
    localparam int         PW   = $clog2(D) + 1;
    localparam logic [7:0] DRST = 8'h5A;

    logic rst = 0, wr_clk = 0, rd_clk = 0, wr_en = 0, rd_en = 0;
    logic [W-1:0] wr_data = '0;
    logic wr_full, wr_almost_full, wr_prog_full, wr_ack, wr_overflow, wr_rst_busy;
    logic [PW-1:0] wr_count, rd_count;
    logic [W-1:0] rd_data;
    logic rd_valid, rd_empty, rd_almost_empty, rd_prog_empty, rd_underflow;

    int n_run = 0, n_fail = 0;

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    dcfifo_rstctl #(
        .WIDTH(W), .DEPTH(D), .SYNC_STAGES(2), .PROG_FULL_LVL(6),
        .PROG_EMPTY_LVL(2), .FULL_RST_VAL(1'b1), .DOUT_RST_VAL(DRST)
    ) uut (
        .rst(rst), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_almost_full(wr_almost_full),
        .wr_prog_full(wr_prog_full), .wr_ack(wr_ack), .wr_overflow(wr_overflow),
        .wr_count(wr_count), .wr_rst_busy(wr_rst_busy), .rd_clk(rd_clk),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty),
        .rd_prog_empty(rd_prog_empty), .rd_underflow(rd_underflow),
        .rd_count(rd_count));

    // bit 8 set: read and expect bits 7:0; clear: write bits 7:0
    localparam logic [8:0] OPS [14] = '{
        9'h0A1, 9'h0A2, 9'h0A3, 9'h1A1, 9'h1A2, 9'h0B1, 9'h0B2,
        9'h0B3, 9'h0B4, 9'h1A3, 9'h1B1, 9'h1B2, 9'h1B3, 9'h1B4};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic do_write(input logic [7:0] v, input logic exp_ack, input string tag);
        @(negedge wr_clk);
        wr_en = 1; wr_data = v;
        @(negedge wr_clk);
        check(tag, wr_ack, exp_ack);
        wr_en = 0;
    endtask

    task automatic do_read(input logic [7:0] exp, input string tag);
        int guard = 0;
        @(negedge rd_clk);
        while (rd_empty && guard < 50) begin
            @(negedge rd_clk);
            guard++;
        end
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
        check({tag, " valid"}, rd_valid, 1'b1);
        check({tag, " data"}, rd_data, exp);
    endtask

    task automatic pulse_reset(input logic hold_wr, output int busy_cycles);
        @(negedge wr_clk);
        rst = 1; wr_en = hold_wr; wr_data = 8'h11;
        @(negedge wr_clk);
        rst = 0;
        busy_cycles = 0;
        check("R1 busy after pulse", wr_rst_busy, 1'b1);
        check("R2 full during busy", {wr_full, wr_almost_full, wr_prog_full}, 3'b111);
        while (wr_rst_busy && busy_cycles < 200) begin
            check("R2 count during busy", wr_count, 0);
            check("R5 no ack during busy", {wr_ack, wr_overflow}, 2'b00);
            @(negedge wr_clk);
            busy_cycles++;
        end
        wr_en = 0;
        check("R1 busy falls", wr_rst_busy, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int bc;
        #2;
        // R4: values before any reset
        check("R4 full flags", {wr_full, wr_almost_full, wr_prog_full}, 3'b000);
        check("R4 empty flags", {rd_empty, rd_almost_empty, rd_prog_empty}, 3'b111);
        check("R4 counts", {wr_count, rd_count}, 0);
        check("R4 strobes", {wr_ack, wr_overflow, rd_valid, rd_underflow, wr_rst_busy}, 0);
        check("R4 rd_data", rd_data, DRST);

        // R1/R2/R5: single-cycle pulse with writes held on
        pulse_reset(1'b1, bc);
        check("R1 busy length >= 3", bc >= 3, 1'b1);
        repeat (10) @(negedge wr_clk);
        check("R5 nothing stored wr_count", wr_count, 0);
        check("R5 nothing stored rd_empty", rd_empty, 1'b1);
        check("R3 rd_data after reset", rd_data, DRST);

        // R6: vector table
        foreach (OPS[i]) begin
            if (OPS[i][8]) do_read(OPS[i][7:0], "R6 table read");
            else do_write(OPS[i][7:0], 1'b1, "R6 table write ack");
        end
        repeat (10) @(negedge wr_clk);
        check("R9 drained wr_count", wr_count, 0);

        // R9/R10: fill and watch thresholds
        for (int k = 1; k <= D; k++) begin
            do_write(8'hC0 + 8'(k - 1), 1'b1, "R6 fill ack");
            check("R9 wr_count", wr_count, k);
            check("R10 prog_full", wr_prog_full, k >= 6);
            check("R9 almost_full", wr_almost_full, k >= D - 1);
            check("R9 full", wr_full, k == D);
        end
        // R7: write while full
        do_write(8'hEE, 1'b0, "R7 no ack when full");
        check("R7 overflow", wr_overflow, 1'b1);
        check("R7 count unchanged", wr_count, D);
        repeat (6) @(negedge rd_clk);
        check("R9 rd_count full", rd_count, D);
        check("R9 rd flags full", {rd_empty, rd_almost_empty, rd_prog_empty}, 3'b000);
        for (int k = 0; k < D - 1; k++) begin
            do_read(8'hC0 + 8'(k), "R6 drain");
            check("R9 rd_count", rd_count, D - 1 - k);
            check("R10 prog_empty", rd_prog_empty, (D - 1 - k) <= 2);
            check("R9 almost_empty", rd_almost_empty, (D - 1 - k) <= 1);
        end

        // R11/R3: reset with one word still stored
        pulse_reset(1'b0, bc);
        repeat (6) @(negedge rd_clk);
        check("R11 wr_count", wr_count, 0);
        check("R11 wr_full", wr_full, 1'b0);
        check("R11 rd_count", rd_count, 0);
        check("R11 rd_empty", rd_empty, 1'b1);
        check("R3 rd_data reset value", rd_data, DRST);
        check("R3 rd_valid", rd_valid, 1'b0);

        // R8: read while empty
        @(negedge rd_clk);
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
        check("R8 underflow", rd_underflow, 1'b1);
        check("R8 no valid", rd_valid, 1'b0);
        check("R8 data kept", rd_data, DRST);

        // R6: normal use after reset
        do_write(8'hD5, 1'b1, "R6 post-reset ack");
        do_read(8'hD5, "R6 post-reset read");

        finish_run();
    end
endmodule